// File: doc/BRIEF.md
# Interrupt Flag Controller for a Four-Phase 8-Bit Core

This block collects interrupt events for a small 8-bit processor core and keeps them in one 8-bit control/status register. It has three sources. The first is an external pin that reacts to one edge, with the polarity picked by an input. The second is a change detector on a narrow input port. The third is the wrap of a free-running timer count from all-ones to zero. Each source sets a sticky flag in the register. Each flag has its own enable bit, and one global enable sits above them. Software reads and writes the register through a plain write strobe and a read-data bus. The flags clear only when software writes them.

The block also produces the four-phase instruction clock (phases Q1, Q2, Q3, Q4). Its timing depends on this clock. The external flag may only rise at the end of a Q4 or Q1 cycle. The port comparison latch reloads on a port read in Q2. The vector request is decided in Q1. The phase sequencer runs through the states Q1 → Q2 → Q3 → Q4 → Q1 and takes one clock cycle per state.

A second machine drives the vector request. It has the states IDLE and REQUEST:
- IDLE → REQUEST happens at the end of a Q1 cycle when the global enable is set and an enabled flag is pending.
- REQUEST → IDLE happens when the core acknowledges. The global enable is cleared on that same edge.
- REQUEST → IDLE also happens at the end of a Q1 cycle in which the condition no longer holds.

A separate wake output tells a sleeping core that an enabled flag is pending, whatever the global enable says.

Top module: `irq_flag_ctl`

## Requirements
- R1: The phase output `q_phase` encodes Q1=0, Q2=1, Q3=2, Q4=3. It is 0 in reset and advances by one (modulo 4) on every clock.
- R2: With `edge_rising`=1, a rising edge of `ext_pin` sets register bit 1. With `edge_rising`=0, a falling edge sets it. The opposite edge leaves bit 1 clear.
- R3: Bit 1 is only set by hardware on a clock edge that closes a Q4 or Q1 cycle. An edge detected in Q2 or Q3 is held and applied at the end of the next Q4. The first sample that shows the flag therefore shows `q_phase` 0 or 1.
- R4: A mismatch between the synchronised `port_pins` and the comparison latch sets bit 0 for as long as it lasts. A `port_rd` pulse seen at the end of a Q2 cycle loads the latch with the pins.
- R5: A pin change that first reaches the comparator in the same Q2 cycle as a port read is absorbed into the latch and does not set bit 0.
- R6: `tmr_count` going from all-ones to zero between two clocks sets bit 2. Any other transition (for example FE→00 or FF→01) does not.
- R7: The register fields, MSB first, are: global enable, peripheral enable, timer enable, external enable, port enable, timer flag, external flag, port flag. A write loads all eight bits as written. Flags stay set until a write clears them.
- R8: `wake` is high exactly when some flag in bits 2..0 has its enable set (bit 5, 4 or 3 respectively). This holds regardless of bit 7.
- R9: `vec_req` rises only after a Q1 cycle in which bit 7 was set and `wake` was high. It is first seen in Q2.
- R10: `vec_ack` while `vec_req` is high clears bit 7 and drops `vec_req` on the same edge. The flags are left unchanged.
- R11: A `retfie` pulse sets bit 7.
- R12: Reset clears the register and drives `vec_req` and `wake` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| edge_rising | input | 1 | 1 selects rising edge, 0 selects falling edge |
| port_pins | input | PORT_W | Monitored port bits, asynchronous |
| port_rd | input | 1 | Port read strobe; acts in Q2 |
| tmr_count | input | TMR_W | Current timer count |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| vec_ack | input | 1 | Core takes the vector |
| retfie | input | 1 | Return from interrupt; sets global enable |
| vec_req | output | 1 | Vector request to the core |
| wake | output | 1 | Wake-up from sleep |
| q_phase | output | 2 | Current instruction phase |

## Verification
The hardest case to reach is the lost port change. A pin edge has to cross the two-stage synchroniser and arrive at the comparator in exactly the Q2 cycle in which a read strobe is sampled. The bench waits for the Q4 phase on `q_phase` and changes the pins there. It then raises `port_rd` for the following Q2 cycle only, so the two events meet in the same cycle. The same test, run without the aligned read, shows the flag being set. The external-edge sweep also shifts the edge through all four phases, so that both the held case and the immediate case of the phase window are seen.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic {
        VS_IDLE = 1'b0,
        VS_REQ  = 1'b1
    } vec_state_e;

    localparam int CTL_W    = 8;
    localparam int FLAG_LO  = 0;   // port, external, timer flags
    localparam int EN_LO    = 3;   // matching enables, same order
    localparam int N_SRC    = 3;
    localparam int BIT_PORT = 0;
    localparam int BIT_EXT  = 1;
    localparam int BIT_TMR  = 2;
    localparam int BIT_GIE  = 7;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
    import irq_flag_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              edge_rising,
    input  logic              ext_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic              port_rd,
    input  logic [TMR_W-1:0]  tmr_count,
    output logic              set_ext,
    output logic              set_port,
    output logic              set_tmr
);
    logic              ext_prev;
    logic              ext_hold;
    logic [PORT_W-1:0] port_latch;
    logic [TMR_W-1:0]  tmr_prev;

    logic edge_hit;
    logic ext_window;
    logic read_now;

    always_comb begin
        edge_hit   = edge_rising ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
        ext_window = (phase == PH_Q4) || (phase == PH_Q1);
        read_now   = port_rd && (phase == PH_Q2);
        set_ext    = (edge_hit || ext_hold) && ext_window;
        set_port   = (port_s != port_latch) && !read_now;
        set_tmr    = (&tmr_prev) && (tmr_count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev   <= 1'b0;
            ext_hold   <= 1'b0;
            port_latch <= '0;
            tmr_prev   <= '0;
        end else begin
            ext_prev <= ext_s;
            ext_hold <= (edge_hit || ext_hold) && !ext_window;
            tmr_prev <= tmr_count;
            if (read_now) port_latch <= port_s;
        end
    end
endmodule

// File: rtl/irq_vec_fsm.sv
module irq_vec_fsm
    import irq_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   gie,
    input  logic   any_pend,
    input  logic   vec_ack,
    output phase_e phase,
    output logic   vec_req,
    output logic   take
);
    phase_e     ph_q, ph_n;
    vec_state_e vs_q, vs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_Q1;
            vs_q <= VS_IDLE;
        end else begin
            ph_q <= ph_n;
            vs_q <= vs_n;
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_Q1: ph_n = PH_Q2;
            PH_Q2: ph_n = PH_Q3;
            PH_Q3: ph_n = PH_Q4;
            PH_Q4: ph_n = PH_Q1;
        endcase

        vs_n = vs_q;
        unique case (vs_q)
            VS_IDLE: if (ph_q == PH_Q1 && gie && any_pend) vs_n = VS_REQ;
            VS_REQ: begin
                if (vec_ack)                                   vs_n = VS_IDLE;
                else if (ph_q == PH_Q1 && !(gie && any_pend))  vs_n = VS_IDLE;
            end
        endcase
    end

    always_comb begin
        phase   = ph_q;
        vec_req = (vs_q == VS_REQ);
        take    = (vs_q == VS_REQ) && vec_ack;
    end
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
    import irq_flag_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rising,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              port_rd,
    input  logic [TMR_W-1:0]  tmr_count,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              vec_ack,
    input  logic              retfie,
    output logic              vec_req,
    output logic              wake,
    output logic [1:0]        q_phase
);
    logic [CTL_W-1:0]  ctl_q, ctl_n;
    logic              ext_s;
    logic [PORT_W-1:0] port_s;
    logic              set_ext, set_port, set_tmr;
    logic              any_pend, take;
    phase_e            phase;

    irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_port (
        .clk(clk), .rst_n(rst_n), .d(port_pins), .q(port_s)
    );

    irq_src_detect #(.PORT_W(PORT_W), .TMR_W(TMR_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .edge_rising(edge_rising), .ext_s(ext_s),
        .port_s(port_s), .port_rd(port_rd), .tmr_count(tmr_count),
        .set_ext(set_ext), .set_port(set_port), .set_tmr(set_tmr)
    );

    irq_vec_fsm u_vec (
        .clk(clk), .rst_n(rst_n), .gie(ctl_q[BIT_GIE]),
        .any_pend(any_pend), .vec_ack(vec_ack),
        .phase(phase), .vec_req(vec_req), .take(take)
    );

    assign any_pend = |(ctl_q[FLAG_LO +: N_SRC] & ctl_q[EN_LO +: N_SRC]);

    always_comb begin
        ctl_n = ctl_q;
        if (reg_wr)   ctl_n = reg_wdata;
        if (set_port) ctl_n[BIT_PORT] = 1'b1;
        if (set_ext)  ctl_n[BIT_EXT]  = 1'b1;
        if (set_tmr)  ctl_n[BIT_TMR]  = 1'b1;
        if (take)     ctl_n[BIT_GIE]  = 1'b0;
        if (retfie)   ctl_n[BIT_GIE]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_n;
    end

    assign reg_rdata = ctl_q;
    assign wake      = any_pend;
    assign q_phase   = phase;
endmodule

// File: rtl/irq_flag_ctl_chk.sv
module irq_flag_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] q_phase,
    input logic [2:0] flags,
    input logic       gie,
    input logic       reg_wr,
    input logic       vec_req,
    input logic       vec_ack,
    input logic       retfie
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> q_phase == 2'($past(q_phase) + 2'd1));

    a_r3_ext_window: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(flags[1]) && !$past(reg_wr)) |->
            ($past(q_phase) == 2'd3 || $past(q_phase) == 2'd0));

    a_r7_port_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flags[0])) |-> $past(reg_wr));

    a_r7_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flags[1])) |-> $past(reg_wr));

    a_r7_tmr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flags[2])) |-> $past(reg_wr));

    a_r9_req_at_q1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(vec_req)) |-> ($past(q_phase) == 2'd0 && $past(gie)));

    a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack && !retfie) |=> (!vec_req && !gie));

    a_r11_retfie_sets: assert property (@(posedge clk) disable iff (!rst_n)
        retfie |=> gie);
endmodule

bind irq_flag_ctl irq_flag_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .q_phase(q_phase),
    .flags(reg_rdata[2:0]), .gie(reg_rdata[7]), .reg_wr(reg_wr),
    .vec_req(vec_req), .vec_ack(vec_ack), .retfie(retfie)
);

// File: tb/irq_flag_ctl_tb_top.sv
module irq_flag_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       edge_rising = 1'b1;
    logic [3:0] port_pins = '0;
    logic       port_rd = 1'b0;
    logic [7:0] tmr_count = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       vec_ack = 1'b0;
    logic       retfie = 1'b0;
    logic       vec_req;
    logic       wake;
    logic [1:0] q_phase;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rising(edge_rising),
        .port_pins(port_pins), .port_rd(port_rd), .tmr_count(tmr_count),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_ack(vec_ack), .retfie(retfie), .vec_req(vec_req),
        .wake(wake), .q_phase(q_phase)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_in_q2();
        @(negedge clk);
        while (q_phase != 2'd1) @(negedge clk);
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    initial begin
        // R12 / R1: reset state
        cyc(2);
        chk("R12 reg after reset", reg_rdata, 8'h00);
        chk("R12 vec_req in reset", vec_req, 1'b0);
        chk("R12 wake in reset", wake, 1'b0);
        chk("R1 phase in reset", q_phase, 2'd0);
        rst_n = 1'b1;
        cyc(1);
        for (int i = 0; i < 8; i++) begin
            logic [1:0] prev;
            prev = q_phase;
            @(negedge clk);
            chk("R1 phase step", q_phase, 2'(prev + 2'd1));
        end

        // R7: write loads all bits; flags with no enable leave wake low (R8)
        wr(8'h47);
        chk("R7 write readback", reg_rdata, 8'h47);
        chk("R8 wake masked", wake, 1'b0);
        wr(8'h09);
        cyc(1);
        chk("R8 wake without global enable", wake, 1'b1);
        cyc(6);
        chk("R9 no request without global enable", vec_req, 1'b0);
        wr(8'h00);
        chk("R7 software clear", reg_rdata, 8'h00);

        // R2 / R3: polarity and phase window sweep
        for (int sel = 0; sel < 2; sel++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int off = 0; off < 4; off++) begin
                    int ph;
                    edge_rising = sel[0];
                    ext_pin = ~dir[0];
                    cyc(8);
                    wr(8'h00);
                    cyc(off);
                    ext_pin = dir[0];
                    ph = -1;
                    for (int k = 0; k < 12; k++) begin
                        @(negedge clk);
                        if (reg_rdata[1] && ph < 0) ph = q_phase;
                    end
                    chk("R2 edge polarity", reg_rdata[1], (sel == dir) ? 1 : 0);
                    if (sel == dir)
                        chk("R3 flag phase window", (ph == 0 || ph == 1) ? 1 : 0, 1);
                end
            end
        end
        ext_pin = 1'b0;
        edge_rising = 1'b1;
        cyc(8);
        wr(8'h00);

        // R4 / R5: every nonzero port pattern, then a lost change back to zero
        for (int v = 1; v < 16; v++) begin
            port_pins = 4'(v);
            cyc(6);
            chk("R4 change sets flag", reg_rdata[0], 1'b1);
            read_in_q2();
            cyc(4);
            wr(8'h00);
            cyc(4);
            chk("R4 latch follows read", reg_rdata[0], 1'b0);
            @(negedge clk);
            while (q_phase != 2'd3) @(negedge clk);
            port_pins = 4'd0;
            @(negedge clk);
            @(negedge clk);
            port_rd = 1'b1;
            @(negedge clk);
            port_rd = 1'b0;
            cyc(6);
            chk("R5 change lost at Q2 read", reg_rdata[0], 1'b0);
        end

        // R6: timer wrap sweep
        for (int a = 0; a < 256; a++) begin
            tmr_count = 8'(a);
            wr(8'h00);
            tmr_count = 8'(a + 1);
            cyc(3);
            chk("R6 timer wrap", reg_rdata[2], (a == 255) ? 1 : 0);
        end
        tmr_count = 8'hFE;
        wr(8'h00);
        tmr_count = 8'h00;
        cyc(3);
        chk("R6 FE to 00 ignored", reg_rdata[2], 1'b0);
        tmr_count = 8'hFF;
        wr(8'h00);
        tmr_count = 8'h01;
        cyc(3);
        chk("R6 FF to 01 ignored", reg_rdata[2], 1'b0);

        // R7..R11: vector sequence using the external source
        edge_rising = 1'b1;
        ext_pin = 1'b0;
        cyc(6);
        wr(8'h00);
        ext_pin = 1'b1;
        cyc(10);
        chk("R2 rising sets flag", reg_rdata, 8'h02);
        chk("R8 wake masked by enable", wake, 1'b0);
        cyc(20);
        chk("R7 flag sticky", reg_rdata[1], 1'b1);
        wr(8'h12);
        cyc(8);
        chk("R8 wake enabled", wake, 1'b1);
        chk("R9 no request with global off", vec_req, 1'b0);
        wr(8'h92);
        begin
            int ph;
            ph = -1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (vec_req && ph < 0) ph = q_phase;
            end
            chk("R9 request first seen in Q2", ph, 1);
        end
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        chk("R10 request dropped", vec_req, 1'b0);
        chk("R10 global cleared flags kept", reg_rdata, 8'h12);
        cyc(10);
        chk("R10 stays idle", vec_req, 1'b0);
        retfie = 1'b1;
        @(negedge clk);
        retfie = 1'b0;
        chk("R11 retfie sets global", reg_rdata[7], 1'b1);
        cyc(8);
        chk("R11 request again", vec_req, 1'b1);
        wr(8'h00);
        cyc(8);
        chk("R8 wake cleared", wake, 1'b0);
        chk("R9 request withdrawn at Q1", vec_req, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule